// File: doc/BRIEF.md
# Power-Management Command Port Controller

This block sits behind a one-byte power-management command port. Each byte the host writes is sorted into one of three kinds. Two reserved codes switch the system between legacy mode and ACPI mode by setting or clearing the SCI enable flag, and they never signal the system-management handler. Every other code requests a system-management interrupt, but only when a gating bit in a small local configuration window is set. The block does not act on the command data beyond this sorting.

The configuration window holds four bytes at offsets 0x58 to 0x5B, and software can read and write each of them one byte at a time. The gating bit is bit 1 of the byte at 0x5B. If the block is built with SMM support switched off, that byte comes out of reset as 0x02. The gate is then already open, which marks the system-management code as already initialised. The SMI request is a level output. It stays high until the handler pulses the acknowledge input.

The command input is a valid/ready stream. The block accepts one byte on every cycle in which `cmd_valid` is high, and it never applies back-pressure. The command port has no read side.

Top module: `pm_cmd_port`

## Requirements
- R1: After reset, the bytes at 0x58, 0x59 and 0x5A read 0x00 and `sci_en` and `smi_req` are low. The byte at 0x5B reads 0x00 when SMM_SUPPORTED is 1 and 0x02 when it is 0.
- R2: An accepted command 0xF1 drives `sci_en` high in the cycle after acceptance.
- R3: An accepted command 0xF0 drives `sci_en` low in the cycle after acceptance.
- R4: An accepted 0xF1 or 0xF0 never sets `smi_req`, whatever the gating bit holds, and it does not clear a request that is already pending.
- R5: An accepted command other than 0xF1 or 0xF0 drives `smi_req` high in the cycle after acceptance when bit 1 of byte 0x5B is 1.
- R6: An accepted command other than 0xF1 or 0xF0 leaves `smi_req` low when bit 1 of byte 0x5B is 0.
- R7: `smi_req` stays high until `smi_ack` is sampled high, and it is low in the following cycle. When a new request and `smi_ack` arrive in the same cycle, the request wins and `smi_req` stays high.
- R8: Accepting 0xF1 while `sci_en` is already high leaves `sci_en` high and raises no SMI.
- R9: A write with `cfg_wr_en` high to an offset from 0x58 to 0x5B replaces only that byte, and `cfg_rdata` returns it from the next cycle on. Writes outside the window change no byte, and reads outside the window return 0x00.
- R10: `cmd_ready` is high in every cycle after reset. Bytes on `cmd_data` while `cmd_valid` is low have no effect on `sci_en` or `smi_req`.
- R11: A command accepted in the same cycle as a write to byte 0x5B is gated by the value the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Always high: the port never stalls |
| cmd_data | input | 8 | Command byte |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| smi_ack | input | 1 | Clears a pending SMI request |
| sci_en | output | 1 | ACPI mode flag (SCI enable) |
| smi_req | output | 1 | Level SMI request |

## Verification
The hardest case to reach is the race between the command path and the configuration path. It shows up when a command lands in the same cycle as a write that opens or closes the gate, and when a new request meets an acknowledge. The stimulus drives both collisions on purpose. It flips the gating byte in the very cycle a non-ACPI code is accepted, in both directions. It also presents a request and `smi_ack` together. After each collision it reads the port outputs one cycle later to confirm that the old gate value and the request take priority.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;
  typedef enum logic [1:0] {
    CMD_ACPI_ON  = 2'd0,
    CMD_ACPI_OFF = 2'd1,
    CMD_TRAP     = 2'd2
  } cmd_kind_t;
endpackage

// File: rtl/pm_cfg_bank.sv
module pm_cfg_bank #(
  parameter int          ADDR_W        = 8,
  parameter int          CFG_BASE      = 'h58,
  parameter int          CFG_BYTES     = 4,
  parameter int          GATE_IDX      = 3,
  parameter int          GATE_BIT      = 1,
  parameter bit          SMM_SUPPORTED = 1'b1,
  parameter logic [7:0]  SMM_DONE_MARK = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              gate
);
  logic [CFG_BYTES-1:0][7:0] bank;

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + i);
    localparam logic [7:0] RST_VAL =
      (i == GATE_IDX && !SMM_SUPPORTED) ? SMM_DONE_MARK : 8'h00;
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= RST_VAL;
      else if (wr_en && addr == MY_ADDR)
        byte_q <= wdata;
    end
    assign bank[i] = byte_q;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < CFG_BYTES; i++)
      if (addr == ADDR_W'(CFG_BASE + i))
        rdata = bank[i];
  end

  assign gate = bank[GATE_IDX][GATE_BIT];

  logic outside;
  assign outside = (int'(addr) < CFG_BASE) || (int'(addr) >= CFG_BASE + CFG_BYTES);

  // R9
  outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && outside) |=> $stable(bank));

  // R9
  inside_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !outside) |=> (rdata == $past(wdata) || addr != $past(addr)));
endmodule

// File: rtl/pm_cmd_decode.sv
module pm_cmd_decode
  import pm_cmd_pkg::*;
#(
  parameter logic [7:0] CODE_ON  = 8'hF1,
  parameter logic [7:0] CODE_OFF = 8'hF0
) (
  input  logic [7:0] data,
  output cmd_kind_t  kind
);
  always_comb begin
    if (data == CODE_ON)
      kind = CMD_ACPI_ON;
    else if (data == CODE_OFF)
      kind = CMD_ACPI_OFF;
    else
      kind = CMD_TRAP;
  end
endmodule

// File: rtl/pm_ctl_state.sv
module pm_ctl_state
  import pm_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  cmd_kind_t kind,
  input  logic      gate,
  input  logic      ack,
  output logic      sci_en,
  output logic      smi_req
);
  logic smi_set;
  assign smi_set = accept && kind == CMD_TRAP && gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en <= 1'b0;
    end else if (accept) begin
      if (kind == CMD_ACPI_ON)
        sci_en <= 1'b1;
      else if (kind == CMD_ACPI_OFF)
        sci_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      smi_req <= 1'b0;
    else if (smi_set)
      smi_req <= 1'b1;
    else if (ack)
      smi_req <= 1'b0;
  end

  // R2
  acpi_on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CMD_ACPI_ON) |=> sci_en);

  // R3
  acpi_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == CMD_ACPI_OFF) |=> !sci_en);

  // R4
  acpi_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind != CMD_TRAP) |=> (smi_req == $past(smi_req && !ack)));

  // R7
  smi_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !ack) |=> smi_req);

  // R7
  smi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(accept && kind == CMD_TRAP && gate)) |=> !smi_req);
endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port
  import pm_cmd_pkg::*;
#(
  parameter int         ADDR_W        = 8,
  parameter int         CFG_BASE      = 'h58,
  parameter int         CFG_BYTES     = 4,
  parameter int         GATE_IDX      = 3,
  parameter int         GATE_BIT      = 1,
  parameter bit         SMM_SUPPORTED = 1'b1,
  parameter logic [7:0] CODE_ON       = 8'hF1,
  parameter logic [7:0] CODE_OFF      = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_data,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smi_ack,
  output logic              sci_en,
  output logic              smi_req
);
  cmd_kind_t kind;
  logic      gate;
  logic      accept;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid && cmd_ready;

  pm_cfg_bank #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES),
    .GATE_IDX(GATE_IDX), .GATE_BIT(GATE_BIT), .SMM_SUPPORTED(SMM_SUPPORTED),
    .SMM_DONE_MARK(8'h02)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .gate(gate)
  );

  pm_cmd_decode #(.CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)) u_dec (
    .data(cmd_data), .kind(kind)
  );

  pm_ctl_state u_state (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind), .gate(gate),
    .ack(smi_ack), .sci_en(sci_en), .smi_req(smi_req)
  );

  // R5
  trap_raises_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data != CODE_ON && cmd_data != CODE_OFF && gate) |=> smi_req);

  // R10
  idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !smi_ack) |=> ($stable(sci_en) && (smi_req == $past(smi_req))));
endmodule

// File: tb/sim_pm_cmd_port.sv
module sim_pm_cmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cfg_wr_en = 1'b0, smi_ack = 1'b0;
  logic [7:0] cmd_data = 8'h00, cfg_addr = 8'h00, cfg_wdata = 8'h00;
  logic cmd_ready, sci_en, smi_req;
  logic [7:0] cfg_rdata;
  logic [7:0] u1_addr = 8'h5B;
  logic [7:0] u1_rdata;
  logic u1_ready, u1_sci, u1_smi;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic exp_sci_q[$];
  logic exp_smi_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pm_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smi_ack(smi_ack),
    .sci_en(sci_en), .smi_req(smi_req)
  );

  pm_cmd_port #(.SMM_SUPPORTED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(1'b0), .cmd_ready(u1_ready),
    .cmd_data(8'h00), .cfg_wr_en(1'b0), .cfg_addr(u1_addr),
    .cfg_wdata(8'h00), .cfg_rdata(u1_rdata), .smi_ack(1'b0),
    .sci_en(u1_sci), .smi_req(u1_smi)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered outputs one cycle after each driven step
  always @(negedge clk) begin
    if (exp_sci_q.size() > 0) begin
      string t;
      logic es, em;
      es = exp_sci_q.pop_front();
      em = exp_smi_q.pop_front();
      t = tag_q.pop_front();
      check({t, " sci_en"}, {7'd0, sci_en}, {7'd0, es});
      check({t, " smi_req"}, {7'd0, smi_req}, {7'd0, em});
    end
  end

  // Driver: one cycle of stimulus, expectation pushed for the following negedge
  task automatic step(input logic v, input logic [7:0] d, input logic ack,
                      input logic wr, input logic [7:0] a, input logic [7:0] wd,
                      input logic es, input logic em, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_data = d; smi_ack = ack;
    cfg_wr_en = wr; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
    exp_sci_q.push_back(es);
    exp_smi_q.push_back(em);
    tag_q.push_back(tag);
    #1;
    cmd_valid = 1'b0; smi_ack = 1'b0; cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    cfg_read(8'h58, 8'h00, "R1 byte58");
    cfg_read(8'h59, 8'h00, "R1 byte59");
    cfg_read(8'h5A, 8'h00, "R1 byte5A");
    cfg_read(8'h5B, 8'h00, "R1 byte5B smm");
    #1 check("R1 u1 byte5B no-smm", u1_rdata, 8'h02);
    check("R1 sci_en", {7'd0, sci_en}, 8'h00);
    check("R1 smi_req", {7'd0, smi_req}, 8'h00);
    check("R10 ready", {7'd0, cmd_ready}, 8'h01);
    // R6 gate closed
    step(1, 8'h42, 0, 0, 8'h00, 8'h00, 0, 0, "R6 gate closed");
    // R9 window access
    step(0, 8'h00, 0, 1, 8'h59, 8'hA5, 0, 0, "R9 write59");
    step(0, 8'h00, 0, 1, 8'h5C, 8'hFF, 0, 0, "R9 write5C");
    step(0, 8'h00, 0, 1, 8'h57, 8'h3C, 0, 0, "R9 write57");
    cfg_read(8'h59, 8'hA5, "R9 read59");
    cfg_read(8'h5A, 8'h00, "R9 neighbour5A");
    cfg_read(8'h58, 8'h00, "R9 neighbour58");
    cfg_read(8'h5C, 8'h00, "R9 outside5C");
    cfg_read(8'h57, 8'h00, "R9 outside57");
    // open gate
    step(0, 8'h00, 0, 1, 8'h5B, 8'h02, 0, 0, "R9 write5B");
    cfg_read(8'h5B, 8'h02, "R9 read5B");
    // R10 idle data ignored
    step(0, 8'h42, 0, 0, 8'h00, 8'h00, 0, 0, "R10 idle data");
    step(0, 8'hF1, 0, 0, 8'h00, 8'h00, 0, 0, "R10 idle F1");
    // R5, R7
    step(1, 8'h42, 0, 0, 8'h00, 8'h00, 0, 1, "R5 trap gated");
    step(0, 8'h00, 0, 0, 8'h00, 8'h00, 0, 1, "R7 hold");
    step(0, 8'h00, 0, 0, 8'h00, 8'h00, 0, 1, "R7 hold2");
    step(0, 8'h00, 1, 0, 8'h00, 8'h00, 0, 0, "R7 ack");
    // R2 R3 R4 R8
    step(1, 8'hF1, 0, 0, 8'h00, 8'h00, 1, 0, "R2 on / R4");
    step(1, 8'hF1, 0, 0, 8'h00, 8'h00, 1, 0, "R8 on again");
    step(1, 8'hF0, 0, 0, 8'h00, 8'h00, 0, 0, "R3 off / R4");
    step(1, 8'hF0, 0, 0, 8'h00, 8'h00, 0, 0, "R3 off again");
    // R7 set beats ack
    step(1, 8'h10, 1, 0, 8'h00, 8'h00, 0, 1, "R7 set wins");
    // R4 pending request untouched by ACPI codes
    step(1, 8'hF1, 0, 0, 8'h00, 8'h00, 1, 1, "R4 pending kept");
    step(0, 8'h00, 1, 0, 8'h00, 8'h00, 1, 0, "R7 ack2");
    // R11 closing gate in the same cycle uses old value
    step(1, 8'h77, 0, 1, 8'h5B, 8'h00, 1, 1, "R11 close same cycle");
    step(0, 8'h00, 1, 0, 8'h00, 8'h00, 1, 0, "R7 ack3");
    step(1, 8'h77, 0, 0, 8'h00, 8'h00, 1, 0, "R6 after close");
    // R11 opening gate in the same cycle uses old value
    step(1, 8'h88, 0, 1, 8'h5B, 8'h02, 1, 0, "R11 open same cycle");
    step(1, 8'h88, 0, 0, 8'h00, 8'h00, 1, 1, "R5 after open");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule